// File: doc/BRIEF.md
# Pin-Lean Program Memory Load and Readback Port

This block is the device-side logic that loads and reads back a one-time-programmable program memory of 16-bit words through a port with no address pins. A 4-bit mode input selects one of four operations: address clear, write, verify, or program inhibit. An internal 13-bit word pointer moves forward only in response to pulses on a separate programming clock. Data moves one byte at a time.

The programming clock is sampled in the system clock domain through a short synchronizer. Each word takes a group of four programming pulses. The first two pulses address the low byte and the last two the high byte. The pointer steps on the falling edge of the third pulse.

A programmer works through the memory in a fixed sequence. It clears the pointer, writes a word, reads it back in verify mode, and uses inhibit mode to skip words. The storage is a register array that only the first 2^STORE_AW words of the address space populate.

Top module: `sprom_prog_port`

## Requirements
- R1: After reset the pointer is word 0 at pulse phase 0, `data_oe` is low, and every stored word reads 16'hFFFF (erased).
- R2: Bit 0 of `mode_sel` carries the first mode line and bit 3 the last. `data_oe` is high only when `mode_sel` is 4'b1100 (verify). When `data_oe` is low, `data_out` is 8'h00.
- R3: While `mode_sel` is 4'b0101 (address clear), the pointer and pulse phase are held at zero and programming pulses have no effect.
- R4: In write, verify and inhibit modes the pointer advances by exactly one word per group of four programming pulses. The step happens on the falling edge of the third pulse.
- R5: In verify mode, phases 0 and 1 drive the low byte of the addressed word. Phase 2 drives its high byte. Phase 3, after the step, still drives that same high byte. The next group then shows the next word.
- R6: In write mode (4'b1110), the low byte is taken from `data_in` at the fall of the second pulse. The high byte is taken at the fall of the third pulse, and at that moment the word is programmed.
- R7: Programming ANDs the new word into the stored word. A 0 bit never returns to 1.
- R8: Inhibit codes 4'b1101 and 4'b1111 step the pointer like write mode but never change memory.
- R9: Any code other than 4'b0101, 4'b1110, 4'b1100, 4'b1101 or 4'b1111 ignores pulses. It changes neither the pointer, the phase nor the memory.
- R10: The pointer wraps from word 16'h1FFF to word 0 on a step.
- R11: Words at or above 2^STORE_AW (1024 by default) read 16'hFFFF, and writes to them are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_clk | input | 1 | Programming pulse input, asynchronous to clk |
| mode_sel | input | 4 | Mode code, bit 0 is the first mode line |
| data_in | input | 8 | Byte presented by the programmer in write mode |
| data_out | output | 8 | Byte driven back in verify mode |
| data_oe | output | 1 | High when the port drives `data_out` onto the shared bus |

## Verification
Several checks run on every cycle:
- The output enable only ever appears under the verify code.
- Address clear leaves the pointer and phase at zero.
- Every pointer change is a single modulo step that follows a detected fall in phase 2.
- Unlisted codes freeze the pointer and phase.

The bench scenarios show the data-dependent behaviour:
- the byte order within a group;
- one-way bit clearing over repeated writes;
- inhibit and unlisted codes leaving memory intact;
- the wrap back to word 0 after a full walk;
- erased reads and dropped writes above the populated range.

// File: rtl/prom_pkg.sv
package prom_pkg;
    typedef enum logic [2:0] {
        PM_CLEAR,
        PM_WRITE,
        PM_VERIFY,
        PM_INHIBIT,
        PM_IDLE
    } prog_mode_e;

    localparam logic [3:0] CODE_CLEAR  = 4'b0101;
    localparam logic [3:0] CODE_WRITE  = 4'b1110;
    localparam logic [3:0] CODE_VERIFY = 4'b1100;
endpackage

// File: rtl/prom_mode_dec.sv
module prom_mode_dec
    import prom_pkg::*;
(
    input  logic [3:0] mode_sel,
    output prog_mode_e mode
);
    always_comb begin
        casez (mode_sel)
            CODE_CLEAR:  mode = PM_CLEAR;
            CODE_WRITE:  mode = PM_WRITE;
            CODE_VERIFY: mode = PM_VERIFY;
            4'b11?1:     mode = PM_INHIBIT;
            default:     mode = PM_IDLE;
        endcase
    end
endmodule

// File: rtl/prom_pulse_sense.sv
module prom_pulse_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    logic [SYNC_STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SYNC_STAGES-2:0], pin};
    end

    assign fall = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES-2];
endmodule

// File: rtl/prom_cell_array.sv
module prom_cell_array #(
    parameter int ADDR_W   = 13,
    parameter int STORE_AW = 10,
    parameter int WORD_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wr_word,
    output logic [WORD_W-1:0] rd_word
);
    localparam int DEPTH = 1 << STORE_AW;

    logic [WORD_W-1:0]   cells_q [DEPTH];
    logic [STORE_AW-1:0] idx;
    logic                in_range;

    assign idx = addr[STORE_AW-1:0];

    generate
        if (STORE_AW < ADDR_W) begin : g_partial
            assign in_range = (addr[ADDR_W-1:STORE_AW] == '0);
        end else begin : g_full
            assign in_range = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells_q[i] <= '1;
        end else if (wr_en && in_range) begin
            cells_q[idx] <= cells_q[idx] & wr_word;
        end
    end

    assign rd_word = in_range ? cells_q[idx] : '1;
endmodule

// File: rtl/sprom_prog_port.sv
module sprom_prog_port
    import prom_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int STORE_AW    = 10,
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prog_clk,
    input  logic [3:0]          mode_sel,
    input  logic [WORD_W/2-1:0] data_in,
    output logic [WORD_W/2-1:0] data_out,
    output logic                data_oe
);
    localparam int BYTE_W = WORD_W / 2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [1:0]        phase;
        logic [BYTE_W-1:0] lo_byte;
        logic [BYTE_W-1:0] hold_hi;
    } port_state_t;

    port_state_t       st_d, st_q;
    prog_mode_e        mode;
    logic              fall_evt;
    logic              wr_en;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] wr_word;
    logic [ADDR_W-1:0] cur_addr;
    logic [1:0]        cur_phase;

    prom_mode_dec u_dec (
        .mode_sel (mode_sel),
        .mode     (mode)
    );

    prom_pulse_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (prog_clk),
        .fall  (fall_evt)
    );

    prom_cell_array #(
        .ADDR_W   (ADDR_W),
        .STORE_AW (STORE_AW),
        .WORD_W   (WORD_W)
    ) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (st_q.addr),
        .wr_word (wr_word),
        .rd_word (rd_word)
    );

    assign wr_word = {data_in, st_q.lo_byte};

    always_comb begin
        st_d  = st_q;
        wr_en = 1'b0;
        unique case (mode)
            PM_CLEAR: begin
                st_d.addr  = '0;
                st_d.phase = '0;
            end
            PM_WRITE, PM_VERIFY, PM_INHIBIT: begin
                if (fall_evt) begin
                    st_d.phase = st_q.phase + 2'd1;
                    if (st_q.phase == 2'd1 && mode == PM_WRITE) begin
                        st_d.lo_byte = data_in;
                    end
                    if (st_q.phase == 2'd2) begin
                        st_d.hold_hi = rd_word[WORD_W-1:BYTE_W];
                        st_d.addr    = st_q.addr + 1'b1;
                        wr_en        = (mode == PM_WRITE);
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_oe = (mode == PM_VERIFY);

    always_comb begin
        if (!data_oe) begin
            data_out = '0;
        end else begin
            unique case (st_q.phase)
                2'd0, 2'd1: data_out = rd_word[BYTE_W-1:0];
                2'd2:       data_out = rd_word[WORD_W-1:BYTE_W];
                default:    data_out = st_q.hold_hi;
            endcase
        end
    end

    assign cur_addr  = st_q.addr;
    assign cur_phase = st_q.phase;
endmodule

// File: rtl/prom_port_checker.sv
module prom_port_checker #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        mode_sel,
    input logic              prog_fall,
    input logic [ADDR_W-1:0] addr,
    input logic [1:0]        phase,
    input logic              data_oe
);
    logic unlisted;
    logic is_clear;

    always_comb begin
        unlisted = !(mode_sel inside {4'b0101, 4'b1110, 4'b1100, 4'b1101, 4'b1111});
        is_clear = (mode_sel == 4'b0101);
    end

    AST_OE_ONLY_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (mode_sel == 4'b1100)); // R2

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        is_clear |=> (addr == '0) && (phase == 2'd0)); // R3

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != $past(addr)) && !$past(is_clear) |-> (addr == $past(addr) + 1'b1)); // R10

    AST_STEP_ON_THIRD_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != $past(addr)) && !$past(is_clear) |-> $past(prog_fall) && ($past(phase) == 2'd2)); // R4

    AST_UNLISTED_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        unlisted |=> $stable(addr) && $stable(phase)); // R9
endmodule

bind sprom_prog_port prom_port_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .prog_fall (fall_evt),
    .addr      (cur_addr),
    .phase     (cur_phase),
    .data_oe   (data_oe)
);

// File: tb/sprom_prog_port_bench.sv
module sprom_prog_port_bench;
    localparam logic [3:0] M_CLR = 4'b0101;
    localparam logic [3:0] M_WR  = 4'b1110;
    localparam logic [3:0] M_VF  = 4'b1100;
    localparam logic [3:0] M_IN1 = 4'b1101;
    localparam logic [3:0] M_IN2 = 4'b1111;

    // each entry: {second write, first write}
    localparam logic [31:0] PAIRS [0:5] = '{
        {16'hFFFF, 16'hA5C3},
        {16'hF0FF, 16'h0F0F},
        {16'h1234, 16'h1234},
        {16'hFF00, 16'h00FF},
        {16'h7E81, 16'hFFFF},
        {16'hFFFE, 16'h8001}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_clk = 1'b0;
    logic [3:0] mode_sel = M_CLR;
    logic [7:0] data_in = 8'h00;
    logic [7:0] data_out;
    logic       data_oe;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sprom_prog_port u_sprom_prog_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_clk (prog_clk),
        .mode_sel (mode_sel),
        .data_in  (data_in),
        .data_out (data_out),
        .data_oe  (data_oe)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [3:0] m);
        @(negedge clk) mode_sel = m;
        @(negedge clk);
    endtask

    task automatic pulse();
        @(negedge clk) prog_clk = 1'b1;
        @(negedge clk) prog_clk = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic fast_walk(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) prog_clk = 1'b1;
            @(negedge clk) prog_clk = 1'b0;
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic write_word(input logic [15:0] w);
        data_in = w[7:0];
        pulse();
        pulse();
        data_in = w[15:8];
        pulse();
        pulse();
    endtask

    task automatic read_word(input logic [15:0] exp, input string req);
        check(data_out == exp[7:0], req, {8'h00, data_out}, {8'h00, exp[7:0]});
        pulse();
        check(data_out == exp[7:0], req, {8'h00, data_out}, {8'h00, exp[7:0]});
        pulse();
        check(data_out == exp[15:8], req, {8'h00, data_out}, {8'h00, exp[15:8]});
        pulse();
        check(data_out == exp[15:8], req, {8'h00, data_out}, {8'h00, exp[15:8]});
        pulse();
    endtask

    function automatic logic [15:0] merged(input int i);
        return 16'hFFFF & PAIRS[i][15:0] & PAIRS[i][31:16];
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2: reset state with the clear code applied
        check(data_oe == 1'b0, "R1 oe after reset", {15'd0, data_oe}, 16'd0);
        check(data_out == 8'h00, "R2 idle bus", {8'h00, data_out}, 16'd0);
        set_mode(M_VF);
        check(data_oe == 1'b1, "R2 verify enables", {15'd0, data_oe}, 16'd1);
        read_word(16'hFFFF, "R1 erased word 0");
        read_word(16'hFFFF, "R1 erased word 1");

        // R6 / R7 / R5: table of write pairs
        set_mode(M_CLR);
        check(data_oe == 1'b0, "R2 clear disables", {15'd0, data_oe}, 16'd0);
        set_mode(M_WR);
        for (int i = 0; i < 6; i++) write_word(PAIRS[i][15:0]);
        set_mode(M_CLR);
        set_mode(M_WR);
        for (int i = 0; i < 6; i++) write_word(PAIRS[i][31:16]);
        set_mode(M_CLR);
        set_mode(M_VF);
        for (int i = 0; i < 6; i++) read_word(merged(i), "R7 one-way program");

        // R3: pulses in clear mode leave the pointer at zero
        set_mode(M_CLR);
        data_in = 8'h00;
        repeat (4) pulse();
        set_mode(M_VF);
        read_word(merged(0), "R3 clear ignores pulses");

        // R9: unlisted code freezes phase and pointer
        set_mode(M_CLR);
        set_mode(M_VF);
        pulse();
        set_mode(4'b0000);
        check(data_oe == 1'b0, "R2 unlisted no drive", {15'd0, data_oe}, 16'd0);
        check(data_out == 8'h00, "R2 unlisted bus zero", {8'h00, data_out}, 16'd0);
        repeat (3) pulse();
        set_mode(M_VF);
        check(data_out == merged(0)[7:0], "R9 phase frozen", {8'h00, data_out}, {8'h00, merged(0)[7:0]});
        pulse();
        check(data_out == merged(0)[15:8], "R9 pointer frozen", {8'h00, data_out}, {8'h00, merged(0)[15:8]});
        set_mode(M_CLR);
        set_mode(4'b0110);
        write_word(16'h0000);
        set_mode(M_CLR);
        set_mode(M_VF);
        read_word(merged(0), "R9 unlisted no write");

        // R8: both inhibit codes step without programming
        set_mode(M_CLR);
        set_mode(M_IN1);
        write_word(16'h0000);
        set_mode(M_IN2);
        write_word(16'h0000);
        set_mode(M_VF);
        read_word(merged(2), "R8 inhibit steps to word 2");
        set_mode(M_CLR);
        set_mode(M_VF);
        read_word(merged(0), "R8 word 0 intact");
        read_word(merged(1), "R8 word 1 intact");

        // R11 / R10: write above the populated range, then wrap
        set_mode(M_CLR);
        set_mode(M_WR);
        data_in = 8'hFF;
        fast_walk(4 * 1024);
        write_word(16'h0000);
        set_mode(M_IN1);
        fast_walk(4 * (8192 - 1025));
        set_mode(M_VF);
        read_word(merged(0), "R10 wrap to word 0");
        set_mode(M_CLR);
        set_mode(M_VF);
        fast_walk(4 * 1023);
        read_word(16'hFFFF, "R11 last stored word erased");
        read_word(16'hFFFF, "R11 unpopulated word reads erased");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule